// File: doc/BRIEF.md
# Dual-Mechanism Configuration-Space Access Decoder

This block sits on the host side of a PCI hierarchy. It watches single-cycle CPU I/O accesses and turns the right ones into configuration reads and writes. Each request carries a bus number, device select, function and register index toward the device side. The block has two access methods. In the first, a 32-bit address register describes the target and four byte-wide data ports reach its registers. In the second, an older method, a key nibble opens a 4 KB I/O window in which each device owns a 256-byte page.

A mode register, written at run time, chooses the method. Every write to the mode register also wipes the shared target fields. The device side answers each request combinationally: it reports whether a device is populated at the presented bus and device, and it supplies the read byte. A request goes out as a strobe in the same cycle as the I/O access. Read data comes back in that same cycle.

Top module: `pcicfg_decoder`

## Requirements
- R1: After reset, with switching enabled, the block is in the window method (mode 0). Byte reads of 0x0CFB and 0x0CF8 return 0x00, and a read at 0xC000 returns 0xFF and issues no request.
- R2: In mode 1, a dword write to 0x0CF8 loads the fields register index = bits 7:0, function = bits 10:8, device = bits 15:11, bus = bits 23:16 and enable = bit 31. A dword read of 0x0CF8 returns those fields at the same positions, with bits 30:24 reading 0.
- R3: In mode 1 with enable set, a byte access to 0x0CFC–0x0CFF issues a request. The request carries the latched bus, device and function, and a register equal to the latched index OR address bits 1:0. `req_write` follows the access direction, a write carries `io_wdata[7:0]`, and a read returns `tgt_rdata` in `io_rdata[7:0]`.
- R4: In mode 1 with enable clear, data-port reads return 0xFF and data-port writes issue no request.
- R5: When `tgt_present` is low for the presented target, a configuration read returns 0xFF and no request is issued, for reads or for writes.
- R6: In mode 0, a byte write to 0x0CF8 sets function = bits 3:1 and key = bits 7:4. A byte read of 0x0CF8 returns key in bits 7:4, function in bits 3:1 and 0 in bit 0.
- R7: In mode 0 with a nonzero key, a byte access in 0xC000–0xCFFF issues a request. It carries device = address bits 11:8 (device bit 4 = 0), register = address bits 7:0, and the latched function and bus.
- R8: In mode 0 with a zero key, window accesses issue no request and reads return 0xFF.
- R9: In mode 0, a byte write to 0x0CFA sets the bus number and a byte read returns it. In either mode, a byte read of 0x0CFB returns the mode in bit 0.
- R10: A byte write to 0x0CFB clears index, device, function, bus and key, keeps the enable bit, and sets the mode to data bit 0 (1 = address-register method, 0 = window method).
- R11: Accesses outside the ports the current mode decodes change no state, issue no request, and read 0xFF (byte) or 0xFFFFFFFF (dword). Examples are 0x0CFA or 0x0CF8 as a byte in mode 1, and 0x0CFC or a dword 0x0CF8 in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_dword | input | 1 | 1 = 32-bit access, 0 = byte access |
| io_wdata | input | 32 | Write data (bytes use bits 7:0) |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 32 | Read data, combinational |
| req_valid | output | 1 | Configuration request strobe |
| req_write | output | 1 | 1 = configuration write |
| req_bus | output | 8 | Target bus number |
| req_dev | output | 5 | Target device select |
| req_func | output | 3 | Target function |
| req_regnum | output | 8 | Target register index |
| req_wdata | output | 8 | Configuration write byte |
| tgt_present | input | 1 | A device is populated at the presented bus and device |
| tgt_rdata | input | 8 | Read byte from the target |

## Verification
The bench targets the mode-register write. It must wipe the shared fields but keep the enable bit. A design that kept a stale key would leave the window open after a return to mode 0. A design that also cleared enable would make the first data access after a same-mode write read 0xFF. The byte-lane OR into the register index and the device taken from window address bits 11:8 are each checked at a distinct address. Mistaking the two would send requests to the wrong register or device. The bench also checks absent targets, a zero key and accesses in the wrong mode, where a loose decoder would emit stray requests or change state.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int IDX_W  = 8;
  localparam int KEY_W  = 4;

  localparam logic [15:0] P_ADDR = 16'h0CF8;
  localparam logic [15:0] P_BUS  = 16'h0CFA;
  localparam logic [15:0] P_MODE = 16'h0CFB;
  localparam logic [13:0] P_DATA_Q = 14'h033F;  // 0x0CFC >> 2
  localparam logic [3:0]  WIN_NIB  = 4'hC;

  typedef struct packed {
    logic              en;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [IDX_W-1:0]  idx;
  } sel_t;

  function automatic sel_t unpack_sel(input logic [31:0] w);
    sel_t s;
    s.en   = w[31];
    s.bus  = w[23:16];
    s.dev  = w[15:11];
    s.func = w[10:8];
    s.idx  = w[7:0];
    return s;
  endfunction

  function automatic logic [31:0] pack_sel(input sel_t s);
    return {s.en, 7'b0, s.bus, s.dev, s.func, s.idx};
  endfunction

  function automatic logic [7:0] key_readback(input logic [KEY_W-1:0] k,
                                              input logic [FUNC_W-1:0] f);
    return {k, f, 1'b0};
  endfunction

  function automatic logic [IDX_W-1:0] lane_reg(input logic [IDX_W-1:0] idx,
                                                input logic [1:0] lane);
    return idx | {{(IDX_W-2){1'b0}}, lane};
  endfunction
endpackage

// File: rtl/cfgdec_state.sv
module cfgdec_state
  import cfgdec_pkg::*;
#(
  parameter bit SWITCHABLE  = 1'b1,
  parameter bit START_MECH1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  sel_t              sel_wv,
  input  logic              key_we,
  input  logic [7:0]        byte_wv,
  input  logic              bus_we,
  input  logic              mode_we,
  output sel_t              sel_q,
  output logic [KEY_W-1:0]  key_q,
  output logic              mode_q
);
  localparam bit RESET_MODE = SWITCHABLE ? 1'b0 : START_MECH1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      key_q  <= '0;
      mode_q <= RESET_MODE;
    end else if (mode_we) begin
      sel_q.bus  <= '0;
      sel_q.dev  <= '0;
      sel_q.func <= '0;
      sel_q.idx  <= '0;
      key_q      <= '0;
      mode_q     <= byte_wv[0];
    end else begin
      if (sel_we) sel_q <= sel_wv;
      if (key_we) begin
        sel_q.func <= byte_wv[3:1];
        key_q      <= byte_wv[7:4];
      end
      if (bus_we) sel_q.bus <= byte_wv;
    end
  end
endmodule

// File: rtl/cfgdec_decode.sv
module cfgdec_decode
  import cfgdec_pkg::*;
#(
  parameter bit SWITCHABLE = 1'b1
) (
  input  logic [15:0]       io_addr,
  input  logic              io_dword,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              mode_q,
  input  sel_t              sel_q,
  input  logic [KEY_W-1:0]  key_q,
  input  logic              tgt_present,
  input  logic [7:0]        tgt_rdata,
  output logic              sel_we,
  output logic              key_we,
  output logic              bus_we,
  output logic              mode_we,
  output logic              cfg_hit,
  output logic              req_valid,
  output logic [BUS_W-1:0]  req_bus,
  output logic [DEV_W-1:0]  req_dev,
  output logic [FUNC_W-1:0] req_func,
  output logic [IDX_W-1:0]  req_regnum,
  output logic [31:0]       io_rdata
);
  logic hit_sel, hit_key, hit_bus, hit_mode, hit_data, hit_win;

  always_comb begin
    hit_sel  = mode_q  &  io_dword & (io_addr == P_ADDR);
    hit_key  = !mode_q & !io_dword & (io_addr == P_ADDR);
    hit_bus  = !mode_q & !io_dword & (io_addr == P_BUS);
    hit_mode = SWITCHABLE & !io_dword & (io_addr == P_MODE);
    hit_data = mode_q  & !io_dword & (io_addr[15:2] == P_DATA_Q) & sel_q.en;
    hit_win  = !mode_q & !io_dword & (io_addr[15:12] == WIN_NIB) & (key_q != '0);
    cfg_hit  = hit_data | hit_win;

    sel_we  = io_wr & hit_sel;
    key_we  = io_wr & hit_key;
    bus_we  = io_wr & hit_bus;
    mode_we = io_wr & hit_mode;

    req_bus  = sel_q.bus;
    req_func = sel_q.func;
    if (mode_q) begin
      req_dev    = sel_q.dev;
      req_regnum = lane_reg(sel_q.idx, io_addr[1:0]);
    end else begin
      req_dev    = {1'b0, io_addr[11:8]};
      req_regnum = io_addr[7:0];
    end
    req_valid = cfg_hit & tgt_present & (io_rd | io_wr);

    if (hit_sel)                      io_rdata = pack_sel(sel_q);
    else if (hit_mode)                io_rdata = {31'b0, mode_q};
    else if (hit_key)                 io_rdata = {24'b0, key_readback(key_q, sel_q.func)};
    else if (hit_bus)                 io_rdata = {24'b0, sel_q.bus};
    else if (cfg_hit && tgt_present)  io_rdata = {24'b0, tgt_rdata};
    else if (io_dword)                io_rdata = 32'hFFFF_FFFF;
    else                              io_rdata = 32'h0000_00FF;
  end
endmodule

// File: rtl/pcicfg_decoder.sv
module pcicfg_decoder
  import cfgdec_pkg::*;
#(
  parameter bit SWITCHABLE  = 1'b1,
  parameter bit START_MECH1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic              io_dword,
  input  logic [31:0]       io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [31:0]       io_rdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [7:0]        req_bus,
  output logic [4:0]        req_dev,
  output logic [2:0]        req_func,
  output logic [7:0]        req_regnum,
  output logic [7:0]        req_wdata,
  input  logic              tgt_present,
  input  logic [7:0]        tgt_rdata
);
  sel_t             sel_q;
  logic [KEY_W-1:0] key_q;
  logic             mode_q;
  logic             sel_we, key_we, bus_we, mode_we, cfg_hit;

  cfgdec_state #(.SWITCHABLE(SWITCHABLE), .START_MECH1(START_MECH1)) u_state (
    .clk(clk), .rst_n(rst_n),
    .sel_we(sel_we), .sel_wv(unpack_sel(io_wdata)),
    .key_we(key_we), .byte_wv(io_wdata[7:0]),
    .bus_we(bus_we), .mode_we(mode_we),
    .sel_q(sel_q), .key_q(key_q), .mode_q(mode_q)
  );

  cfgdec_decode #(.SWITCHABLE(SWITCHABLE)) u_decode (
    .io_addr(io_addr), .io_dword(io_dword), .io_rd(io_rd), .io_wr(io_wr),
    .mode_q(mode_q), .sel_q(sel_q), .key_q(key_q),
    .tgt_present(tgt_present), .tgt_rdata(tgt_rdata),
    .sel_we(sel_we), .key_we(key_we), .bus_we(bus_we), .mode_we(mode_we),
    .cfg_hit(cfg_hit), .req_valid(req_valid),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_regnum(req_regnum), .io_rdata(io_rdata)
  );

  assign req_write = io_wr;
  assign req_wdata = io_wdata[7:0];
endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker #(
  parameter bit SWITCHABLE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_dword,
  input logic [7:0]  io_wbyte,
  input logic        io_rd,
  input logic        io_wr,
  input logic [7:0]  io_rbyte,
  input logic        req_valid,
  input logic        req_write,
  input logic [4:0]  req_dev,
  input logic        tgt_present,
  input logic        mode_q,
  input logic        en_q,
  input logic [7:0]  bus_q,
  input logic [3:0]  key_q
);
  logic data_port;
  assign data_port = !io_dword && (io_addr[15:2] == 14'h033F);

  p_en_gate_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && mode_q && !en_q && data_port) |-> !req_valid);

  p_en_gate_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && mode_q && !en_q && data_port) |-> (io_rbyte == 8'hFF));

  p_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_present |-> !req_valid);

  p_key_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_q) |-> (key_q != 4'h0));

  p_win_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_q) |-> (req_dev[4] == 1'b0));

  p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_write == io_wr));

  p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (SWITCHABLE && io_wr && !io_dword && io_addr == 16'h0CFB) |=>
      (bus_q == 8'h00 && key_q == 4'h0 && mode_q == $past(io_wbyte[0]) && en_q == $past(en_q)));
endmodule

bind pcicfg_decoder cfgdec_checker #(.SWITCHABLE(SWITCHABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_dword(io_dword),
  .io_wbyte(io_wdata[7:0]), .io_rd(io_rd), .io_wr(io_wr), .io_rbyte(io_rdata[7:0]),
  .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
  .tgt_present(tgt_present), .mode_q(mode_q), .en_q(sel_q.en),
  .bus_q(sel_q.bus), .key_q(key_q)
);

// File: tb/pcicfg_decoder_tb_top.sv
module pcicfg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_dword = 1'b0;
  logic [31:0] io_wdata = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_rdata;
  logic        req_valid, req_write;
  logic [7:0]  req_bus, req_regnum, req_wdata, tgt_rdata;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic        tgt_present;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] c_rdata;
  logic        c_req, c_wr;
  logic [7:0]  c_bus, c_reg, c_wd;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;

  always #2 clk = ~clk;

  pcicfg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_dword(io_dword),
    .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
    .req_dev(req_dev), .req_func(req_func), .req_regnum(req_regnum),
    .req_wdata(req_wdata), .tgt_present(tgt_present), .tgt_rdata(tgt_rdata)
  );

  // Device-side model: bus 3 and device 7 are unpopulated.
  function automatic logic [7:0] model_byte(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f, input logic [7:0] r);
    return r ^ {d, f} ^ b;
  endfunction
  always_comb begin
    tgt_present = (req_bus != 8'h03) && (req_dev != 5'd7);
    tgt_rdata   = model_byte(req_bus, req_dev, req_func, req_regnum);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io(input bit is_rd, input logic [15:0] a, input bit dw, input logic [31:0] wd);
    @(negedge clk);
    io_addr = a; io_dword = dw; io_wdata = wd; io_rd = is_rd; io_wr = !is_rd;
    #1;
    c_rdata = io_rdata; c_req = req_valid; c_wr = req_write; c_bus = req_bus;
    c_dev = req_dev; c_func = req_func; c_reg = req_regnum; c_wd = req_wdata;
    @(posedge clk); #1;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic t_reset();
    io(1, 16'h0CFB, 0, 0); chk("R1 mode after reset", c_rdata, 32'h0);
    io(1, 16'h0CF8, 0, 0); chk("R1 key/func after reset", c_rdata, 32'h0);
    io(1, 16'hC000, 0, 0); chk("R1 window closed data", c_rdata, 32'hFF);
    chk("R1 window closed req", c_req, 0);
  endtask

  task automatic t_m2_regs();
    io(0, 16'h0CF8, 0, 32'hA5); io(1, 16'h0CF8, 0, 0);
    chk("R6 key/func readback", c_rdata, 32'hA4);
    io(0, 16'h0CFA, 0, 32'h12); io(1, 16'h0CFA, 0, 0);
    chk("R9 bus readback", c_rdata, 32'h12);
  endtask

  task automatic t_m2_window();
    io(1, 16'hC345, 0, 0);
    chk("R7 req", c_req, 1);
    chk("R7 fields", {c_bus, 3'b0, c_dev, 5'b0, c_func, c_reg}, {8'h12, 3'b0, 5'd3, 5'b0, 3'd2, 8'h45});
    chk("R7 read data", c_rdata, {24'b0, model_byte(8'h12, 5'd3, 3'd2, 8'h45)});
    io(0, 16'hCA10, 0, 32'h5A);
    chk("R7 write req", {c_req, c_wr, c_dev, c_reg, c_wd}, {1'b1, 1'b1, 5'd10, 8'h10, 8'h5A});
    io(1, 16'hC700, 0, 0);
    chk("R5 absent device read", {c_req, c_rdata}, {1'b0, 32'hFF});
    io(0, 16'hC700, 0, 32'h11);
    chk("R5 absent device write", c_req, 0);
  endtask

  task automatic t_m2_ignored();
    io(1, 16'h0CFC, 0, 0);
    chk("R11 data port in mode 0", {c_req, c_rdata}, {1'b0, 32'hFF});
    io(0, 16'h0CF8, 1, 32'hFFFF_FFFF);
    io(1, 16'h0CF8, 0, 0);
    chk("R11 dword CF8 ignored in mode 0", c_rdata, 32'hA4);
    io(1, 16'h0CF8, 1, 0);
    chk("R11 dword read in mode 0", c_rdata, 32'hFFFF_FFFF);
  endtask

  task automatic t_key_zero();
    io(0, 16'h0CF8, 0, 32'h04);
    io(1, 16'hC200, 0, 0);
    chk("R8 zero key closes window", {c_req, c_rdata}, {1'b0, 32'hFF});
    io(0, 16'hC200, 0, 32'h33);
    chk("R8 zero key write", c_req, 0);
    io(1, 16'h0CF8, 0, 0);
    chk("R8 func kept with zero key", c_rdata, 32'h04);
  endtask

  task automatic t_to_mech1();
    io(0, 16'h0CF8, 0, 32'hF0);
    io(0, 16'h0CFB, 0, 32'h01);
    io(1, 16'h0CFB, 0, 0); chk("R10 mode set to 1", c_rdata, 32'h1);
    io(1, 16'h0CF8, 1, 0); chk("R10 fields cleared", c_rdata, 32'h0);
    io(1, 16'h0CFA, 0, 0); chk("R11 CFA ignored in mode 1", c_rdata, 32'hFF);
    io(1, 16'hC345, 0, 0); chk("R10 key cleared, window shut", c_req, 0);
  endtask

  task automatic t_m1();
    io(0, 16'h0CF8, 1, 32'hFF12_5A34);
    io(1, 16'h0CF8, 1, 0); chk("R2 packed readback", c_rdata, 32'h8012_5A34);
    io(1, 16'h0CFE, 0, 0);
    chk("R3 read fields", {c_req, c_wr, c_bus, c_dev, c_func, c_reg},
        {1'b1, 1'b0, 8'h12, 5'd11, 3'd2, 8'h36});
    chk("R3 read data", c_rdata, {24'b0, model_byte(8'h12, 5'd11, 3'd2, 8'h36)});
    io(0, 16'h0CFD, 0, 32'h77);
    chk("R3 write", {c_req, c_wr, c_reg, c_wd}, {1'b1, 1'b1, 8'h35, 8'h77});
    io(0, 16'h0CF8, 0, 32'h00);
    io(1, 16'h0CF8, 1, 0); chk("R11 byte CF8 ignored in mode 1", c_rdata, 32'h8012_5A34);
    io(0, 16'h0CF8, 1, 32'h8000_3800);
    io(1, 16'h0CFC, 0, 0); chk("R5 absent mode 1 read", {c_req, c_rdata}, {1'b0, 32'hFF});
    io(0, 16'h0CFC, 0, 32'h9); chk("R5 absent mode 1 write", c_req, 0);
    io(0, 16'h0CF8, 1, 32'h0012_5A34);
    io(1, 16'h0CFC, 0, 0); chk("R4 disabled read", {c_req, c_rdata}, {1'b0, 32'hFF});
    io(0, 16'h0CFF, 0, 32'h9); chk("R4 disabled write", c_req, 0);
  endtask

  task automatic t_switching();
    io(0, 16'h0CF8, 1, 32'h8012_5A34);
    io(0, 16'h0CFB, 0, 32'h01);
    io(1, 16'h0CF8, 1, 0); chk("R10 enable kept, fields cleared", c_rdata, 32'h8000_0000);
    io(0, 16'h0CFB, 0, 32'h00);
    io(1, 16'h0CFB, 0, 0); chk("R9 mode readback 0", c_rdata, 32'h0);
    io(1, 16'h0CFA, 0, 0); chk("R10 bus cleared in mode 0", c_rdata, 32'h0);
    io(1, 16'h0CF8, 0, 0); chk("R10 key cleared in mode 0", c_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_m2_regs();
    t_m2_window();
    t_m2_ignored();
    t_key_zero();
    t_to_mech1();
    t_m1();
    t_switching();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule